// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer of `INT_W` bits, either 32 or 64. It always truncates toward zero and has no rounding-mode input. The operand arrives as five parts: a sign, a class code, a signed unbiased exponent, a mantissa whose top bit is the integer bit, and the three guard, round and sticky bits left over from earlier arithmetic. The mantissa value is `in_mant * 2^(in_exp - (MANT_W-1))`.

The block accepts one operand per cycle when `in_valid` is high. One cycle later it raises `out_valid` for one cycle and presents the integer together with two flags. `out_inexact` reports that bits were discarded. `out_invalid` reports that the value cannot be represented, or that the operand is not a number. The outputs hold their last values until the next operand is accepted. A two-state controller sequences the block. `ST_IDLE` moves to `ST_EMIT` on an accepted operand. `ST_EMIT` stays in `ST_EMIT` while operands keep arriving, and returns to `ST_IDLE` once `in_valid` drops.

Top module: `f2i_trunc_conv`

## Requirements
- R1: Class code 0 (zero) gives result 0 with both flags clear, whatever the sign and the guard, round and sticky bits.
- R2: With class code 1 (number), an exponent of `INT_W` or more is invalid.
- R3: With class code 1 and an exponent from 0 to `INT_W`-1, the magnitude is the mantissa shifted right by `MANT_W-1-exponent`, with no rounding. `out_inexact` is set exactly when a shifted-out bit or any of guard, round or sticky is 1. For example, 2.75 gives 2 and sets inexact.
- R4: With class code 1 and a negative exponent, the result is 0. `out_inexact` is set exactly when any mantissa bit or any of guard, round or sticky is 1.
- R5: A representable negative value is returned as the two's complement of its truncated magnitude.
- R6: A truncated magnitude of 2^(`INT_W`-1) is accepted only for a negative sign, where it gives the most negative integer. For a positive sign it is invalid.
- R7: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN), and the unused codes 5 to 7, are always invalid.
- R8: Any invalid result sets `out_invalid`, clears `out_inexact` even when bits were lost, and returns 0x7FF..F for a positive sign or 0x800..0 for a negative sign.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Result and flags change only on an accepted operand. The flags describe that operand alone and never accumulate.
- R10: During reset `out_valid`, `out_result`, `out_inexact` and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the operand, 1 = negative |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | EXP_W (16) | Signed unbiased exponent |
| in_mant | input | MANT_W (64) | Mantissa, integer bit at the top |
| in_guard | input | 1 | Guard bit below the mantissa |
| in_round | input | 1 | Round bit below the guard bit |
| in_sticky | input | 1 | OR of all lower bits |
| out_valid | output | 1 | One-cycle pulse when a result is presented |
| out_result | output | INT_W (32) | Signed integer result |
| out_inexact | output | 1 | Bits were discarded by truncation |
| out_invalid | output | 1 | Result saturated: out of range or not a number |

## Verification
Inexact detection and the range check can act on the same operand. The bench provokes this with values such as a negative 0x80000001.00000001 and a positive 0xFFFFFFFF plus a guard bit: bits are lost and the magnitude is out of range at once. It accepts only `out_invalid` set with `out_inexact` clear and the saturated pattern. Loading a new result and presenting the previous one also fall in the same cycle, because the stimulus table is fed back to back with `in_valid` held high. Every cycle is checked against its own operand, so a flag carried over from an earlier operand is caught.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    // class codes seen on in_class; 5..7 are unused and handled as invalid
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fcls_e;

    // controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } conv_st_e;

endpackage

// File: rtl/f2i_align.sv
// Moves the integer part of the mantissa into the low INT_W bits and
// reports whether any nonzero bit fell off the right-hand end.
module f2i_align #(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 16,
    parameter int MANT_W = 64
) (
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    output logic [INT_W-1:0]        mag_o,
    output logic                    lost_o,
    output logic                    big_o
);
    localparam int SH_W = $clog2(MANT_W) + 1;
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);
    localparam logic [SH_W-1:0] TOP_POS = SH_W'(MANT_W - 1);

    logic            neg;
    logic [SH_W-1:0] sh;

    always_comb begin
        neg   = exp_i[EXP_W-1];
        big_o = !neg && (exp_i >= EXP_LIM);
        sh    = '0;
        if (!neg && !big_o) begin
            sh = TOP_POS - exp_i[SH_W-1:0];
        end
        mag_o = neg ? '0 : INT_W'(mant_i >> sh);
        lost_o = 1'b0;
        for (int i = 0; i < MANT_W; i++) begin
            if (neg || (i < int'(sh))) begin
                lost_o = lost_o | mant_i[i];
            end
        end
    end
endmodule

// File: rtl/f2i_pack.sv
// Applies the class decode and the sign-dependent range check, then forms
// the final integer and flags.
module f2i_pack
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign_i,
    input  fcls_e            cls_i,
    input  logic             big_i,
    input  logic             lost_i,
    input  logic             grs_i,
    input  logic [INT_W-1:0] mag_i,
    output logic [INT_W-1:0] result_o,
    output logic             inexact_o,
    output logic             invalid_o
);
    localparam logic [INT_W:0]   HALF    = {2'b01, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MAX = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W:0] limit;
    logic           over;
    logic           bad;

    always_comb begin
        limit = HALF + {{INT_W{1'b0}}, sign_i};
        over  = {1'b0, mag_i} >= limit;
        bad   = 1'b0;
        result_o  = '0;
        inexact_o = 1'b0;
        unique case (cls_i)
            CLS_ZERO: begin
                result_o  = '0;
                inexact_o = 1'b0;
            end
            CLS_NUM: begin
                if (big_i || over) begin
                    bad = 1'b1;
                end else begin
                    result_o  = sign_i ? (~mag_i + 1'b1) : mag_i;
                    inexact_o = lost_i | grs_i;
                end
            end
            default: bad = 1'b1;
        endcase
        if (bad) begin
            result_o  = sign_i ? NEG_MAX : POS_MAX;
            inexact_o = 1'b0;
        end
        invalid_o = bad;
    end
endmodule

// File: rtl/f2i_trunc_conv.sv
module f2i_trunc_conv
    import f2i_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 16,
    parameter int MANT_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic [2:0]              in_class,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic                    in_guard,
    input  logic                    in_round,
    input  logic                    in_sticky,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_result,
    output logic                    out_inexact,
    output logic                    out_invalid
);
    conv_st_e         state_q, state_d;
    logic [INT_W-1:0] mag;
    logic             lost, big;
    logic [INT_W-1:0] res_c;
    logic             inex_c, inv_c;

    f2i_align #(.INT_W(INT_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
        .exp_i  (in_exp),
        .mant_i (in_mant),
        .mag_o  (mag),
        .lost_o (lost),
        .big_o  (big)
    );

    f2i_pack #(.INT_W(INT_W)) u_pack (
        .sign_i    (in_sign),
        .cls_i     (fcls_e'(in_class)),
        .big_i     (big),
        .lost_i    (lost),
        .grs_i     (in_guard | in_round | in_sticky),
        .mag_i     (mag),
        .result_o  (res_c),
        .inexact_o (inex_c),
        .invalid_o (inv_c)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers: load on every accepted operand
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_result  <= res_c;
            out_inexact <= inex_c;
            out_invalid <= inv_c;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/f2i_trunc_conv_chk.sv
module f2i_trunc_conv_chk #(
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sign,
    input logic [2:0]       in_class,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic             out_inexact,
    input logic             out_invalid
);
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MAX = {1'b1, {(INT_W-1){1'b0}}};

    // R9
    accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_invalid)));

    // R1
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd0) |=> (out_result == '0 && !out_inexact && !out_invalid));

    // R7
    non_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class >= 3'd2) |=> out_invalid);

    // R8
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));

    // R8
    saturate_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == ($past(in_sign) ? NEG_MAX : POS_MAX)));
endmodule

bind f2i_trunc_conv f2i_trunc_conv_chk #(.INT_W(INT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_class    (in_class),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
);

// File: tb/f2i_trunc_conv_tb.sv
module f2i_trunc_conv_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W  = 32;
    localparam int EXP_W  = 16;
    localparam int MANT_W = 64;

    typedef struct packed {
        logic [3:0]  req;
        logic        sgn;
        logic [2:0]  cls;
        logic [15:0] ex;
        logic [63:0] mt;
        logic        g;
        logic        r;
        logic        s;
        logic [31:0] res;
        logic        ix;
        logic        iv;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b1, 3'd0, 16'h0000, 64'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0},          // R1 zero
        '{4'd1, 1'b0, 3'd0, 16'h0005, 64'hFFFF, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0},       // R1 zero, grs ignored
        '{4'd3, 1'b0, 3'd1, 16'h0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'd1, 1'b0, 1'b0},
        '{4'd3, 1'b0, 3'd1, 16'h0001, 64'hB000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'd2, 1'b1, 1'b0}, // R3 2.75
        '{4'd5, 1'b1, 3'd1, 16'h0001, 64'hB000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE, 1'b1, 1'b0}, // R5
        '{4'd3, 1'b0, 3'd1, 16'h0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 32'd1, 1'b1, 1'b0}, // R3 guard
        '{4'd5, 1'b1, 3'd1, 16'h0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0},
        '{4'd3, 1'b0, 3'd1, 16'h0002, 64'hA000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'd5, 1'b0, 1'b0},
        '{4'd5, 1'b1, 3'd1, 16'h0002, 64'hA000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFB, 1'b0, 1'b0},
        '{4'd4, 1'b0, 3'd1, 16'hFFFF, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0}, // R4 0.5
        '{4'd4, 1'b1, 3'd1, 16'hFFFF, 64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0},
        '{4'd4, 1'b0, 3'd1, 16'hFFBA, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0},
        '{4'd4, 1'b0, 3'd1, 16'hFFFF, 64'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0},          // R4 exact
        '{4'd3, 1'b0, 3'd1, 16'h001E, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0},
        '{4'd6, 1'b0, 3'd1, 16'h001F, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R6
        '{4'd6, 1'b1, 3'd1, 16'h001F, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0},
        '{4'd6, 1'b1, 3'd1, 16'h001F, 64'h8000_0000_8000_0000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0},
        '{4'd8, 1'b1, 3'd1, 16'h001F, 64'h8000_0001_0000_0001, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b1}, // R8
        '{4'd8, 1'b0, 3'd1, 16'h001F, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1},
        '{4'd2, 1'b0, 3'd1, 16'h0020, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R2
        '{4'd2, 1'b1, 3'd1, 16'h00C8, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 1'b0, 1'b1},
        '{4'd7, 1'b0, 3'd2, 16'h0000, 64'h0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1},  // R7 inf
        '{4'd7, 1'b1, 3'd3, 16'h0000, 64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b1},
        '{4'd7, 1'b0, 3'd4, 16'h0000, 64'hA000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1},
        '{4'd7, 1'b1, 3'd5, 16'h0000, 64'h0, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b1}   // R7 unused code
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_sign = 1'b0;
    logic [2:0]              in_class = 3'd0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [MANT_W-1:0]       in_mant = '0;
    logic                    in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
    logic                    out_valid;
    logic [INT_W-1:0]        out_result;
    logic                    out_inexact, out_invalid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_trunc_conv #(.INT_W(INT_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
        .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
        .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        in_sign   = v.sgn;
        in_class  = v.cls;
        in_exp    = v.ex;
        in_mant   = v.mt;
        in_guard  = v.g;
        in_round  = v.r;
        in_sticky = v.s;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10 out_valid", 64'(out_valid), 64'd0);
        check("R10 out_result", 64'(out_result), 64'd0);
        check("R10 out_inexact", 64'(out_inexact), 64'd0);
        check("R10 out_invalid", 64'(out_invalid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table, fed back to back (R9 streaming)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), 64'(out_result), 64'(VECS[i].res));
            check($sformatf("R%0d vec %0d inexact", VECS[i].req, i), 64'(out_inexact), 64'(VECS[i].ix));
            check($sformatf("R%0d vec %0d invalid", VECS[i].req, i), 64'(out_invalid), 64'(VECS[i].iv));
            check($sformatf("R9 vec %0d out_valid", i), 64'(out_valid), 64'd1);
        end

        // R9 idle: valid drops, outputs held from the last operand
        in_valid = 1'b0;
        in_class = 3'd0;
        in_sign  = 1'b0;
        @(negedge clk);
        check("R9 idle out_valid", 64'(out_valid), 64'd0);
        check("R9 idle result held", 64'(out_result), 64'h8000_0000);
        check("R9 idle invalid held", 64'(out_invalid), 64'd1);

        // R9 flags per operation: inexact 0.5, then exact 3.0
        drive('{4'd4, 1'b0, 3'd1, 16'hFFFF, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 half inexact", 64'(out_inexact), 64'd1);
        check("R9 single pulse", 64'(out_valid), 64'd1);
        @(negedge clk);
        check("R9 pulse ends", 64'(out_valid), 64'd0);
        check("R9 inexact held", 64'(out_inexact), 64'd1);
        drive('{4'd3, 1'b0, 3'd1, 16'h0001, 64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 32'd3, 1'b0, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 no accumulate inexact", 64'(out_inexact), 64'd0);
        check("R3 three result", 64'(out_result), 64'd3);

        // R10 reset again clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reassert result", 64'(out_result), 64'd0);
        check("R10 reassert valid", 64'(out_valid), 64'd0);
        finish_run();
    end
endmodule